// File: doc/BRIEF.md
# Converter clock enable and sample/convert timer

This block paces one analog conversion. It turns a chosen clock source into a converter-clock enable. The source can be the system clock, the system clock divided by two, an alternate tick or an asynchronous tick. The enable is then divided by 1, 2, 4 or 8. Both tick inputs are modelled as single-cycle enables in the system clock domain. No clock is gated.

A start pulse opens a sample phase, and a convert phase follows it. Each phase counts converter-clock enables. The sample phase lasts a short fixed time or one of four long lengths. The convert phase length follows the selected resolution. A high-speed option adds two cycles to the convert phase. At the end, a one-cycle done strobe tells the sequencer the conversion is finished.

All timing settings are captured when the conversion starts and held until it ends. A separate output requests the asynchronous clock. It is raised when a conversion is running from that source, or at all times when its always-on bit is set.

Top module: `adc_clk_timer`

## Requirements
- R1: `src_sel_i` selects the enable source: 00 = every system cycle, 01 = every second system cycle, 10 = each `alt_tick_i` pulse, 11 = each `async_tick_i` pulse. `ce_o` pulses only while `busy_o` is high.
- R2: `div_sel_i` values 00/01/10/11 pass one source enable in 1, 2, 4 or 8 to `ce_o`. The count restarts with each conversion.
- R3: With `long_smp_i` = 0, `sample_o` stays high for exactly 4 converter-clock enables.
- R4: With `long_smp_i` = 1, `long_code_i` values 00/01/10/11 give sample phases of 24, 16, 10 and 6 enables.
- R5: The convert phase lasts the result width plus 2 enables. `res_sel_i` values 00/01/10/11 give widths of 8, 12, 10 and 16 bits.
- R6: With `hs_i` = 1, the convert phase is 2 enables longer.
- R7: `done_o` is high for exactly one system cycle, in the cycle right after the last `convert_o` cycle. `busy_o` is low in that cycle.
- R8: `async_run_o` is high when `async_oe_i` = 1. With `async_oe_i` = 0, it is high only while busy with `src_sel_i` = 11. `async_tick_i` has no effect unless `async_run_o` is high.
- R9: Configuration is captured on the accepted start. Changes to the configuration and `start_i` pulses while busy have no effect on the running conversion.
- R10: After reset, `busy_o`, `sample_o`, `convert_o`, `done_o`, `ce_o` are low, and `async_run_o` follows `async_oe_i`.
- R11: `sample_o` and `convert_o` are never both high. A sample phase is followed directly by a convert phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Enable source select |
| div_sel_i | input | 2 | Divide ratio select |
| long_smp_i | input | 1 | Long sample select |
| long_code_i | input | 2 | Long sample length code |
| hs_i | input | 1 | High-speed option (+2 convert cycles) |
| res_sel_i | input | 2 | Result resolution select |
| async_oe_i | input | 1 | Keep asynchronous clock running |
| alt_tick_i | input | 1 | Alternate source tick |
| async_tick_i | input | 1 | Asynchronous source tick |
| start_i | input | 1 | Conversion start pulse |
| busy_o | output | 1 | Conversion running |
| sample_o | output | 1 | Sample phase strobe |
| convert_o | output | 1 | Convert phase strobe |
| done_o | output | 1 | End-of-conversion pulse |
| ce_o | output | 1 | Converter clock enable |
| async_run_o | output | 1 | Asynchronous clock request |

## Verification
The hardest case to reach from the ports is a conversion that is disturbed while it runs. The divider select changes and a second start arrives in the middle of the sample phase. The test does this from inside its own measuring loop, a few cycles after the start. It then compares phase lengths and enable counts with an undisturbed run. The alternate and asynchronous sources use free-running tick generators whose phase is unknown relative to the start. For those sources, only the number of enables per phase is checked, not the cycle counts.

// File: rtl/adc_ct_pkg.sv
package adc_ct_pkg;
  typedef enum logic [1:0] {
    SRC_BUS      = 2'b00,
    SRC_BUS_HALF = 2'b01,
    SRC_ALT      = 2'b10,
    SRC_ASYNC    = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_SAMPLE  = 2'b01,
    PH_CONVERT = 2'b10
  } phase_e;

  typedef struct packed {
    clk_src_e   src;
    logic [1:0] div;
    logic       long_smp;
    logic [1:0] long_code;
    logic       hs;
    logic [1:0] res;
  } tcfg_t;

  function automatic int long_smp_len(logic [1:0] code);
    case (code)
      2'b00:   return 24;
      2'b01:   return 16;
      2'b10:   return 10;
      default: return 6;
    endcase
  endfunction

  function automatic int res_bits(logic [1:0] res);
    case (res)
      2'b00:   return 8;
      2'b01:   return 12;
      2'b10:   return 10;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/adc_ct_src_sel.sv
module adc_ct_src_sel
  import adc_ct_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  clk_src_e src_i,
  input  logic     alt_tick_i,
  input  logic     async_tick_i,
  input  logic     async_oe_i,
  output logic     tick_o,
  output logic     async_run_o
);
  logic half_q;

  // half-rate phase restarts with each conversion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_q <= 1'b0;
    else if (run_i)  half_q <= ~half_q;
    else             half_q <= 1'b0;
  end

  assign async_run_o = async_oe_i | (run_i & (src_i == SRC_ASYNC));

  always_comb begin
    case (src_i)
      SRC_BUS:      tick_o = 1'b1;
      SRC_BUS_HALF: tick_o = half_q;
      SRC_ALT:      tick_o = alt_tick_i;
      default:      tick_o = async_tick_i & async_run_o;
    endcase
  end
endmodule

// File: rtl/adc_ct_div.sv
module adc_ct_div #(
  parameter int DIV_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] div_i,
  output logic       ce_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;
  logic             wrap;

  assign mask = ~({DIV_W{1'b1}} << div_i);
  assign wrap = (cnt_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (tick_i && wrap)  cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  assign ce_o = run_i & tick_i & wrap;
endmodule

// File: rtl/adc_ct_phase.sv
module adc_ct_phase
  import adc_ct_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ce_i,
  input  logic [CNT_W-1:0] smp_len_i,
  input  logic [CNT_W-1:0] conv_len_i,
  output phase_e           phase_o,
  output logic             done_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             smp_last, conv_last;

  assign smp_last  = ce_i && (cnt_q == smp_len_i  - 1'b1);
  assign conv_last = ce_i && (cnt_q == conv_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start_i) ph_q <= PH_SAMPLE;
        end
        PH_SAMPLE: begin
          if (smp_last) begin
            ph_q  <= PH_CONVERT;
            cnt_q <= '0;
          end else if (ce_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_CONVERT: begin
          if (conv_last) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            done_o <= 1'b1;
          end else if (ce_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/adc_clk_timer.sv
module adc_clk_timer
  import adc_ct_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int DIV_W     = 3,
  parameter int SHORT_SMP = 4,
  parameter int CONV_OVH  = 2,
  parameter int HS_EXTRA  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_sel_i,
  input  logic [1:0] div_sel_i,
  input  logic       long_smp_i,
  input  logic [1:0] long_code_i,
  input  logic       hs_i,
  input  logic [1:0] res_sel_i,
  input  logic       async_oe_i,
  input  logic       alt_tick_i,
  input  logic       async_tick_i,
  input  logic       start_i,
  output logic       busy_o,
  output logic       sample_o,
  output logic       convert_o,
  output logic       done_o,
  output logic       ce_o,
  output logic       async_run_o
);
  tcfg_t            cfg_q;
  phase_e           phase;
  logic             tick;
  logic [CNT_W-1:0] smp_len, conv_len;

  // config tracks inputs while idle, frozen from the accepted start on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (phase == PH_IDLE)
      cfg_q <= '{src: clk_src_e'(src_sel_i), div: div_sel_i, long_smp: long_smp_i,
                 long_code: long_code_i, hs: hs_i, res: res_sel_i};
  end

  always_comb begin
    smp_len  = cfg_q.long_smp ? CNT_W'(long_smp_len(cfg_q.long_code)) : CNT_W'(SHORT_SMP);
    conv_len = CNT_W'(res_bits(cfg_q.res) + CONV_OVH + (cfg_q.hs ? HS_EXTRA : 0));
  end

  assign busy_o    = phase != PH_IDLE;
  assign sample_o  = phase == PH_SAMPLE;
  assign convert_o = phase == PH_CONVERT;

  adc_ct_src_sel i_src (
    .clk_i, .rst_ni,
    .run_i        (busy_o),
    .src_i        (cfg_q.src),
    .alt_tick_i, .async_tick_i, .async_oe_i,
    .tick_o       (tick),
    .async_run_o
  );

  adc_ct_div #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni,
    .run_i  (busy_o),
    .tick_i (tick),
    .div_i  (cfg_q.div),
    .ce_o
  );

  adc_ct_phase #(.CNT_W(CNT_W)) i_phase (
    .clk_i, .rst_ni,
    .start_i,
    .ce_i       (ce_o),
    .smp_len_i  (smp_len),
    .conv_len_i (conv_len),
    .phase_o    (phase),
    .done_o
  );
endmodule

// File: rtl/adc_clk_timer_chk.sv
module adc_clk_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic async_oe_i,
  input logic busy_o,
  input logic sample_o,
  input logic convert_o,
  input logic done_o,
  input logic ce_o,
  input logic async_run_o
);
  logic [5:0] smp_ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                smp_ce_q <= '0;
    else if (!sample_o)         smp_ce_q <= '0;
    else if (ce_o)              smp_ce_q <= smp_ce_q + 1'b1;
  end

  p_phase_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && convert_o));
  p_smp_to_conv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (sample_o || convert_o));
  p_done_after_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(convert_o) && !convert_o && !busy_o));
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> sample_o);
  p_ce_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> busy_o);
  p_async_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_oe_i |-> async_run_o);
  p_smp_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ce_q <= 6'd24);
endmodule

bind adc_clk_timer adc_clk_timer_chk i_chk (
  .clk_i, .rst_ni, .start_i, .async_oe_i, .busy_o, .sample_o,
  .convert_o, .done_o, .ce_o, .async_run_o
);

// File: tb/test_adc_clk_timer.sv
module test_adc_clk_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00, div_sel = 2'b00, long_code = 2'b00, res_sel = 2'b00;
  logic long_smp = 1'b0, hs = 1'b0, async_oe = 1'b0, alt_tick = 1'b0, async_tick = 1'b0, start = 1'b0;
  logic busy, sample, convert, done, ce, async_run;
  int n_chk = 0, n_fail = 0;
  bit async_busy_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_clk_timer i_adc_clk_timer (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .div_sel_i(div_sel),
    .long_smp_i(long_smp), .long_code_i(long_code), .hs_i(hs), .res_sel_i(res_sel),
    .async_oe_i(async_oe), .alt_tick_i(alt_tick), .async_tick_i(async_tick),
    .start_i(start), .busy_o(busy), .sample_o(sample), .convert_o(convert),
    .done_o(done), .ce_o(ce), .async_run_o(async_run)
  );

  // free-running tick generators, driven away from the active edge
  initial forever begin
    repeat (2) @(negedge clk); alt_tick = 1'b1;
    @(negedge clk); alt_tick = 1'b0;
  end
  initial forever begin
    repeat (4) @(negedge clk); async_tick = 1'b1;
    @(negedge clk); async_tick = 1'b0;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_smp(bit lng, logic [1:0] code);
    if (!lng) return 4;
    case (code) 2'b00: return 24; 2'b01: return 16; 2'b10: return 10; default: return 6; endcase
  endfunction

  function automatic int exp_conv(logic [1:0] res, bit h);
    int b;
    case (res) 2'b00: b = 8; 2'b01: b = 12; 2'b10: b = 10; default: b = 16; endcase
    return b + 2 + (h ? 2 : 0);
  endfunction

  // per: system cycles per enable, 0 when the source phase is unknown
  task automatic run_conv(string req, int per, bit poke);
    int s_cyc = 0, c_cyc = 0, s_ce = 0, c_ce = 0, n = 0;
    int es = exp_smp(long_smp, long_code), ec = exp_conv(res_sel, hs);
    bit seen_conv = 0, order_ok = 1;
    logic [1:0] div_keep = div_sel;
    async_busy_all = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 4000) begin
      if (sample) begin s_cyc++; if (ce) s_ce++; if (seen_conv) order_ok = 0; end
      if (convert) begin c_cyc++; if (ce) c_ce++; seen_conv = 1; end
      if (!async_run) async_busy_all = 1'b0;
      if (poke && n == 3) begin start = 1'b1; div_sel = ~div_keep; end
      if (poke && n == 4) start = 1'b0;
      n++;
      @(negedge clk);
    end
    check(n < 4000, {req, " done reached"}, n, 0);
    check(s_ce == es, {req, " sample enables (R3/R4)"}, s_ce, es);
    check(c_ce == ec, {req, " convert enables (R5/R6)"}, c_ce, ec);
    check(order_ok && seen_conv, {req, " R11 order"}, order_ok, 1);
    check(!busy, {req, " R7 busy low with done"}, busy, 0);
    if (per > 0) begin
      check(s_cyc == es * per, {req, " R1/R2 sample cycles"}, s_cyc, es * per);
      check(c_cyc == ec * per, {req, " R1/R2 convert cycles"}, c_cyc, ec * per);
    end
    @(negedge clk);
    check(!done, {req, " R7 done one cycle"}, done, 0);
    div_sel = div_keep;
  endtask

  task automatic t_reset;
    check(!busy && !sample && !convert, "R10 phases idle", {busy, sample, convert}, 0);
    check(!done && !ce, "R10 done/ce low", {done, ce}, 0);
    check(async_run == async_oe, "R10 async_run", async_run, async_oe);
  endtask

  task automatic t_bus_short;
    src_sel = 2'b00; div_sel = 2'b00; long_smp = 0; res_sel = 2'b00; hs = 0;
    run_conv("R3 bus div1 short res8", 1, 0);
  endtask

  task automatic t_half_long_hs;
    src_sel = 2'b01; div_sel = 2'b00; long_smp = 1; long_code = 2'b00; res_sel = 2'b01; hs = 1;
    run_conv("R4 R6 half div1 long24 res12", 2, 0);
  endtask

  task automatic t_div_sweep;
    src_sel = 2'b00; div_sel = 2'b11; long_smp = 1; long_code = 2'b11; res_sel = 2'b10; hs = 0;
    run_conv("R2 bus div8 long6 res10", 8, 0);
    div_sel = 2'b10; long_code = 2'b01; res_sel = 2'b11; hs = 1;
    run_conv("R2 bus div4 long16 res16 hs", 4, 0);
    src_sel = 2'b01; div_sel = 2'b01; long_code = 2'b10; res_sel = 2'b00; hs = 0;
    run_conv("R1 half div2 long10 res8", 4, 0);
  endtask

  task automatic t_alt;
    src_sel = 2'b10; div_sel = 2'b01; long_smp = 0; res_sel = 2'b01; hs = 0; async_oe = 0;
    run_conv("R1 alt div2", 0, 0);
    check(!async_busy_all, "R8 alt source keeps async off", async_busy_all, 0);
  endtask

  task automatic t_async;
    async_oe = 0; src_sel = 2'b11;
    @(negedge clk);
    check(!async_run, "R8 async idle off", async_run, 0);
    div_sel = 2'b00; long_smp = 1; long_code = 2'b11; res_sel = 2'b00; hs = 1;
    run_conv("R8 async div1", 0, 0);
    check(async_busy_all, "R8 async on while busy", async_busy_all, 1);
    async_oe = 1; src_sel = 2'b00;
    @(negedge clk);
    check(async_run, "R8 always-on bit", async_run, 1);
    async_oe = 0;
  endtask

  task automatic t_busy_poke;
    src_sel = 2'b00; div_sel = 2'b01; long_smp = 0; res_sel = 2'b10; hs = 0;
    run_conv("R9 restart and div change ignored", 2, 1);
    @(negedge clk);
    check(!busy, "R9 no second conversion", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_short();
    t_half_long_hs();
    t_div_sweep();
    t_alt();
    t_async();
    t_busy_poke();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule